// File: doc/BRIEF.md
# ADC Calibration and Mode Sequencer

This block sits between a host register interface and the datapath of a sigma-delta converter. It orders conversions and calibrations. The host writes a 3-bit mode code. A write that selects a calibration starts that operation at once. A write that selects normal conversion only stores the code, and a conversion then runs when the host raises a start strobe while the enable bit is set. Each operation goes to the datapath as a one-cycle start pulse with an operation code. The block then waits for a one-cycle done pulse in return.

When a calibration finishes, the stored mode code returns to zero by itself, a sticky done flag is set, and an interrupt is raised if the host has unmasked it. The combined self calibration runs an offset pass and then a gain pass, and it reports completion only once. After reset and after every calibration the block stays idle until the host starts a conversion.

Top module: `adc_cal_sequencer`

## Requirements
- R1: Mode decode. Each mode code maps to a datapath op code: mode 1 gives op 1 (system offset), mode 2 gives op 2 (system gain), mode 5 gives op 3 (self offset) and mode 6 gives op 4 (self gain). Modes 0, 3 and 4 are normal modes, and a conversion run under them uses op 0.
- R2: A host write of a calibration mode (1, 2, 5, 6 or 7) accepted while idle raises `dp_start` in the cycle after the write, carrying the first op code.
- R3: After the final done of a calibration, `mode_rd` reads 0 from the next cycle on. After a normal conversion, `mode_rd` keeps its code.
- R4: `done_flag` sets on the final done of any operation and stays set until a `status_rd` strobe. If a set and a clear fall in the same cycle, the set wins.
- R5: `irq` equals `done_flag` AND the unmask bit last written through `host_unmask`.
- R6: Mode 7 issues op 3 first and then op 4, with a new `dp_start` in the cycle after the first done. The flag and the interrupt stay low until the second done, and `mode_rd` reads 7 until then.
- R7: No `dp_start` occurs after reset or after a calibration until `host_start` arrives with the enable bit set. A start with enable clear does nothing.
- R8: While busy, mode writes leave `mode_rd` unchanged, and neither writes nor start strobes launch an operation.
- R9: `busy` is high from the cycle after an accepted write or start until the cycle after the final done. A `dp_done` is ignored in the cycle of `dp_start` and while idle.
- R10: `dp_start` is exactly one cycle wide for each operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Configuration write strobe |
| host_mode | input | 3 | Mode code written with `host_wr` |
| host_enable | input | 1 | Conversion enable bit, stored on `host_wr` |
| host_unmask | input | 1 | Interrupt unmask bit, stored on `host_wr` |
| host_start | input | 1 | Conversion start strobe |
| status_rd | input | 1 | Status read strobe; clears the done flag |
| dp_start | output | 1 | One-cycle operation start to the datapath |
| dp_op | output | 3 | Operation code presented with `dp_start` |
| dp_done | input | 1 | One-cycle operation done from the datapath |
| mode_rd | output | 3 | Current stored mode code |
| busy | output | 1 | An operation is in progress |
| done_flag | output | 1 | Sticky done status |
| irq | output | 1 | Interrupt request |

## Verification
The block has no tunable parameters, so the bench builds its only configuration. It plays the datapath itself and times each done pulse by hand. This lets a done land in the same cycle as the start pulse, while the block is idle, and together with a status read. Those cases exercise the ignore rules of R9 and the set-wins rule of R4. Every mode code from 0 to 7 is written, so every branch of the decode is reached, including the two-pass chain.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int MODE_W = 3;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_CONV      = 3'd0,
        OP_SYS_OFS   = 3'd1,
        OP_SYS_GAIN  = 3'd2,
        OP_SELF_OFS  = 3'd3,
        OP_SELF_GAIN = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic is_cal;
        logic chained;
        op_e  first_op;
        op_e  second_op;
    } mode_info_t;

    function automatic mode_info_t decode_mode(input logic [MODE_W-1:0] m);
        mode_info_t r;
        r.is_cal    = 1'b0;
        r.chained   = 1'b0;
        r.first_op  = OP_CONV;
        r.second_op = OP_CONV;
        case (m)
            3'd1: begin r.is_cal = 1'b1; r.first_op = OP_SYS_OFS;   end
            3'd2: begin r.is_cal = 1'b1; r.first_op = OP_SYS_GAIN;  end
            3'd5: begin r.is_cal = 1'b1; r.first_op = OP_SELF_OFS;  end
            3'd6: begin r.is_cal = 1'b1; r.first_op = OP_SELF_GAIN; end
            3'd7: begin
                r.is_cal    = 1'b1;
                r.chained   = 1'b1;
                r.first_op  = OP_SELF_OFS;
                r.second_op = OP_SELF_GAIN;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mode_decode.sv
module mode_decode
    import adc_seq_pkg::*;
(
    input  logic [MODE_W-1:0] mode_in,
    output mode_info_t        info
);
    always_comb info = decode_mode(mode_in);

    always_comb begin
        if (info.chained) begin
            a_r6_chain_only_cal: assert (info.is_cal);
        end
    end
endmodule

// File: rtl/op_sequencer.sv
module op_sequencer
    import adc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_wr,
    input  logic [MODE_W-1:0] host_mode,
    input  logic              start_go,
    input  logic              dp_done,
    output logic              dp_start,
    output logic [OP_W-1:0]   dp_op,
    output logic              busy,
    output logic [MODE_W-1:0] mode_q,
    output logic              fin_pulse
);
    seq_st_e    st_q;
    op_e        op_q;
    op_e        second_q;
    logic       chain_q;
    logic       cal_q;
    mode_info_t wr_info;

    mode_decode u_dec (
        .mode_in (host_mode),
        .info    (wr_info)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            mode_q   <= '0;
            op_q     <= OP_CONV;
            second_q <= OP_CONV;
            chain_q  <= 1'b0;
            cal_q    <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (host_wr) begin
                        mode_q <= host_mode;
                        if (wr_info.is_cal) begin
                            op_q     <= wr_info.first_op;
                            second_q <= wr_info.second_op;
                            chain_q  <= wr_info.chained;
                            cal_q    <= 1'b1;
                            st_q     <= ST_ISSUE;
                        end
                    end else if (start_go) begin
                        op_q    <= OP_CONV;
                        chain_q <= 1'b0;
                        cal_q   <= 1'b0;
                        st_q    <= ST_ISSUE;
                    end
                end
                ST_ISSUE: st_q <= ST_WAIT;
                ST_WAIT: begin
                    if (dp_done) begin
                        if (chain_q) begin
                            op_q    <= second_q;
                            chain_q <= 1'b0;
                            st_q    <= ST_ISSUE;
                        end else begin
                            st_q <= ST_IDLE;
                            if (cal_q) mode_q <= '0;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        dp_start  = (st_q == ST_ISSUE);
        dp_op     = op_q;
        busy      = (st_q != ST_IDLE);
        fin_pulse = (st_q == ST_WAIT) && dp_done && !chain_q;
    end

    a_r10_start_one_cycle: assert property (@(posedge clk) disable iff (rst)
        dp_start |=> !dp_start);
    a_r3_mode_clears: assert property (@(posedge clk) disable iff (rst)
        (fin_pulse && cal_q) |=> (mode_q == '0));
    a_r6_second_pass: assert property (@(posedge clk) disable iff (rst)
        ((st_q == ST_WAIT) && dp_done && chain_q) |=> (dp_start && dp_op == OP_SELF_GAIN));
    a_r8_mode_held_busy: assert property (@(posedge clk) disable iff (rst)
        (busy && !fin_pulse) |=> $stable(mode_q));
endmodule

// File: rtl/status_irq.sv
module status_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic unmask,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_evt) flag <= 1'b0;
    end

    always_comb irq = flag & unmask;

    a_r4_flag_sets: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> flag);
    a_r4_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr_evt) |=> flag);
endmodule

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer
    import adc_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_wr,
    input  logic [MODE_W-1:0]     host_mode,
    input  logic                  host_enable,
    input  logic                  host_unmask,
    input  logic                  host_start,
    input  logic                  status_rd,
    output logic                  dp_start,
    output logic [OP_W-1:0]       dp_op,
    input  logic                  dp_done,
    output logic [MODE_W-1:0]     mode_rd,
    output logic                  busy,
    output logic                  done_flag,
    output logic                  irq
);
    logic enable_q;
    logic unmask_q;
    logic start_go;
    logic fin_pulse;

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= 1'b0;
            unmask_q <= 1'b0;
        end else if (host_wr) begin
            enable_q <= host_enable;
            unmask_q <= host_unmask;
        end
    end

    always_comb start_go = host_start && enable_q;

    op_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .host_wr   (host_wr),
        .host_mode (host_mode),
        .start_go  (start_go),
        .dp_done   (dp_done),
        .dp_start  (dp_start),
        .dp_op     (dp_op),
        .busy      (busy),
        .mode_q    (mode_rd),
        .fin_pulse (fin_pulse)
    );

    status_irq u_stat (
        .clk     (clk),
        .rst     (rst),
        .set_evt (fin_pulse),
        .clr_evt (status_rd),
        .unmask  (unmask_q),
        .flag    (done_flag),
        .irq     (irq)
    );

    a_r9_busy_with_start: assert property (@(posedge clk) disable iff (rst)
        dp_start |-> busy);
    a_r7_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
        (!busy && !host_wr && !(host_start && enable_q)) |=> !dp_start);
endmodule

// File: tb/sim_adc_cal_sequencer.sv
`timescale 1ns/1ps
module sim_adc_cal_sequencer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic [2:0] host_mode = 3'd0;
    logic       host_enable = 1'b0;
    logic       host_unmask = 1'b0;
    logic       host_start = 1'b0;
    logic       status_rd = 1'b0;
    logic       dp_done = 1'b0;
    logic       dp_start;
    logic [2:0] dp_op;
    logic [2:0] mode_rd;
    logic       busy;
    logic       done_flag;
    logic       irq;

    int n_run  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #2 clk = ~clk;

    adc_cal_sequencer u0 (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_mode(host_mode),
        .host_enable(host_enable), .host_unmask(host_unmask),
        .host_start(host_start), .status_rd(status_rd),
        .dp_start(dp_start), .dp_op(dp_op), .dp_done(dp_done),
        .mode_rd(mode_rd), .busy(busy), .done_flag(done_flag), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [2:0] m, input logic en, input logic um);
        @(negedge clk);
        host_wr = 1'b1; host_mode = m; host_enable = en; host_unmask = um;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        host_start = 1'b1;
        @(negedge clk);
        host_start = 1'b0;
    endtask

    task automatic give_done();
        dp_done = 1'b1;
        @(negedge clk);
        dp_done = 1'b0;
    endtask

    task automatic read_status();
        @(negedge clk);
        status_rd = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        chk(done_flag == 1'b0, "R4 status read clears flag", done_flag, 0);
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(dp_start == 1'b0, tag, dp_start, 0);
        end
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R9 busy low after reset", busy, 0);
        chk(done_flag == 1'b0, "R4 flag low after reset", done_flag, 0);
        chk(irq == 1'b0, "R5 irq low after reset", irq, 0);
        chk(mode_rd == 3'd0, "R3 mode zero after reset", mode_rd, 0);
        quiet(5, "R7 no start after reset");
    endtask

    task automatic t_single_cal(input logic [2:0] m, input int op);
        write_cfg(m, 1'b1, 1'b1);
        chk(dp_start == 1'b1, "R2 cal start pulse", dp_start, 1);
        chk(dp_op == op[2:0], "R1 cal op code", dp_op, op);
        @(negedge clk);
        chk(dp_start == 1'b0, "R10 start one cycle", dp_start, 0);
        chk(busy == 1'b1, "R9 busy while waiting", busy, 1);
        quiet(3, "R10 no extra start");
        chk(mode_rd == m, "R3 mode held during cal", mode_rd, m);
        give_done();
        chk(mode_rd == 3'd0, "R3 mode cleared after cal", mode_rd, 0);
        chk(done_flag == 1'b1, "R4 flag set after cal", done_flag, 1);
        chk(irq == 1'b1, "R5 irq when unmasked", irq, 1);
        chk(busy == 1'b0, "R9 busy drops after done", busy, 0);
        quiet(4, "R7 idle after cal");
        read_status();
        chk(irq == 1'b0, "R5 irq follows cleared flag", irq, 0);
    endtask

    task automatic t_normal(input logic [2:0] m);
        write_cfg(m, 1'b0, 1'b0);
        chk(dp_start == 1'b0, "R1 normal write starts nothing", dp_start, 0);
        chk(busy == 1'b0, "R1 normal write stays idle", busy, 0);
        chk(mode_rd == m, "R1 normal mode stored", mode_rd, m);
        pulse_start();
        chk(dp_start == 1'b0, "R7 start ignored with enable clear", dp_start, 0);
        write_cfg(m, 1'b1, 1'b0);
        chk(dp_start == 1'b0, "R7 enable alone starts nothing", dp_start, 0);
        pulse_start();
        chk(dp_start == 1'b1, "R7 start with enable", dp_start, 1);
        chk(dp_op == 3'd0, "R1 conversion op code", dp_op, 0);
        @(negedge clk);
        give_done();
        chk(done_flag == 1'b1, "R4 flag set after conversion", done_flag, 1);
        chk(irq == 1'b0, "R5 irq masked", irq, 0);
        chk(mode_rd == m, "R3 normal mode kept", mode_rd, m);
        write_cfg(m, 1'b1, 1'b1);
        chk(irq == 1'b1, "R5 irq after unmask", irq, 1);
        read_status();
    endtask

    task automatic t_chain();
        write_cfg(3'd7, 1'b0, 1'b1);
        chk(dp_start == 1'b1 && dp_op == 3'd3, "R6 first pass self offset", dp_op, 3);
        @(negedge clk);
        give_done();
        chk(dp_start == 1'b1, "R6 second start", dp_start, 1);
        chk(dp_op == 3'd4, "R6 second pass self gain", dp_op, 4);
        chk(done_flag == 1'b0, "R6 no flag mid chain", done_flag, 0);
        chk(irq == 1'b0, "R6 no irq mid chain", irq, 0);
        chk(mode_rd == 3'd7, "R6 mode held mid chain", mode_rd, 7);
        chk(busy == 1'b1, "R9 busy mid chain", busy, 1);
        @(negedge clk);
        give_done();
        chk(done_flag == 1'b1 && irq == 1'b1, "R6 irq after both passes", irq, 1);
        chk(mode_rd == 3'd0, "R3 mode cleared after chain", mode_rd, 0);
        quiet(3, "R7 idle after chain");
        read_status();
    endtask

    task automatic t_busy_ignore();
        write_cfg(3'd5, 1'b1, 1'b1);
        give_done();
        chk(busy == 1'b1, "R9 done in start cycle ignored", busy, 1);
        chk(done_flag == 1'b0, "R9 early done sets nothing", done_flag, 0);
        write_cfg(3'd2, 1'b1, 1'b1);
        chk(mode_rd == 3'd5, "R8 write ignored while busy", mode_rd, 5);
        chk(dp_start == 1'b0, "R8 write launches nothing", dp_start, 0);
        pulse_start();
        chk(dp_start == 1'b0, "R8 start ignored while busy", dp_start, 0);
        give_done();
        chk(mode_rd == 3'd0 && busy == 1'b0, "R3 cal ends normally", mode_rd, 0);
        quiet(3, "R7 idle after ignored requests");
        read_status();
        give_done();
        chk(done_flag == 1'b0 && busy == 1'b0, "R9 stray done while idle ignored", done_flag, 0);
    endtask

    task automatic t_set_wins();
        write_cfg(3'd1, 1'b0, 1'b1);
        @(negedge clk);
        give_done();
        write_cfg(3'd6, 1'b0, 1'b1);
        @(negedge clk);
        chk(done_flag == 1'b1, "R4 flag still set", done_flag, 1);
        status_rd = 1'b1;
        give_done();
        status_rd = 1'b0;
        chk(done_flag == 1'b1, "R4 set wins over clear", done_flag, 1);
        read_status();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single_cal(3'd1, 1);
        t_single_cal(3'd2, 2);
        t_single_cal(3'd5, 3);
        t_single_cal(3'd6, 4);
        t_normal(3'd0);
        t_normal(3'd3);
        t_normal(3'd4);
        t_chain();
        t_busy_ignore();
        t_set_wins();
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule